// File: doc/BRIEF.md
# Page Access Permission Checker

This unit decides whether one memory access may go ahead. It uses the protection data of the page, which arrives with a translation hit: a 7-bit rights code and a 15-bit access ID. It also uses the current privilege level of the requester and the kind of access requested. Four privilege levels exist, with level 0 the most privileged and level 3 the least. The unit holds four loadable protection-ID registers. Each register is a 15-bit ID plus a write-disable flag, and only code running at level 0 can load them.

An access is granted only when both checks pass. The rights code must permit the access type at the current level, and the page ID must be public or must match a loaded register. When the rights check fails, the unit reports a rights fault. When only the ID check fails, it reports an ID fault, so that software can load the missing ID and retry. The write-disable flag lets one page be read-only for one process and writable for another through a single ID.

A request is presented for one cycle. The verdict appears on the registered outputs in the following cycle.

Top module: `prot_check_unit`

## Requirements
- R1: While reset is active and just after it, `res_valid`, `allow`, `rights_fault` and `id_fault` are 0. All four ID registers reset to zero, so an access to a nonzero page ID after reset gives an ID fault.
- R2: The rights code is laid out as kind in bits [6:4], read level in bits [3:2] and write/execute level in bits [1:0]. A read (`req_type` 0) is permitted only for kinds 0 to 3 and only when the current level is at most the read level.
- R3: A write (`req_type` 1) is permitted only for kinds 1 and 3, and only when the current level is at most the write/execute level.
- R4: An execute (`req_type` 2) is permitted only for kinds 2 to 7, and only when the current level is at most the write/execute level. Kinds 4 to 7 permit nothing else. `req_type` 3 is never permitted.
- R5: A nonzero page ID passes the ID check when it equals the ID field (bits [14:0]) of any of the four registers.
- R6: Bit 15 of a register is its write-disable flag. A register with this flag set still passes reads and executes, but a write passes the ID check only if some matching register has the flag clear.
- R7: When the ID check fails and the rights check passes, the verdict is `id_fault` alone.
- R8: Page ID 0 is public and passes the ID check whatever the registers hold.
- R9: A register write (`pid_we`, slot `pid_sel`, value `pid_wdata`) takes effect on the next clock edge only when `priv_lvl` is 0. At any other level it is ignored and all registers keep their values.
- R10: When the rights check fails, the verdict is `rights_fault` alone, even if the ID check also fails.
- R11: The verdict on a request appears one cycle later with `res_valid` high and exactly one of `allow`, `rights_fault` and `id_fault` set. With no request, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege level, 0 most privileged |
| req_valid | input | 1 | Access request present this cycle |
| req_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| page_rights | input | 7 | Per-page rights code |
| page_aid | input | 15 | Per-page access ID |
| pid_we | input | 1 | ID register write request |
| pid_sel | input | 2 | ID register slot to write |
| pid_wdata | input | 16 | {write-disable, ID} value to load |
| res_valid | output | 1 | Verdict present |
| allow | output | 1 | Access granted |
| rights_fault | output | 1 | Rights code forbids the access |
| id_fault | output | 1 | No usable ID register matched |

## Verification
The assertions check the shape of the verdict on every cycle. They confirm that a verdict follows each request by one cycle, that exactly one outcome is flagged, and that nothing is flagged when idle. They also confirm that a public ID never produces an ID fault, that execute-only kinds refuse reads, that read-only pages refuse writes, and that register writes are loaded at level 0 and ignored at other levels.

Only the directed scenarios can show the level comparisons at their boundaries and matching against each of the four slots. They also cover the interplay of write-disable flags across two registers that hold the same ID, and the fault priority on a combined failure. Several of these depend on sequences of register loads, and the scenarios exercise them as sequences.

// File: rtl/prot_check_pkg.sv
package prot_check_pkg;

  localparam int PL_W     = 2;
  localparam int KIND_W   = 3;
  localparam int RIGHTS_W = KIND_W + 2 * PL_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  // Permissions granted by a rights kind, as {read, write, execute}.
  function automatic logic [2:0] kind_perm(input logic [KIND_W-1:0] kind);
    logic rd, wr, ex;
    rd = (kind < 3'd4);
    wr = (kind == 3'd1) || (kind == 3'd3);
    ex = (kind >= 3'd2);
    return {rd, wr, ex};
  endfunction

endpackage

// File: rtl/pid_regfile.sv
module pid_regfile #(
  parameter int NUM_PID = 4,
  parameter int PID_W   = 16,
  localparam int SEL_W  = $clog2(NUM_PID)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               priv_lvl,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [PID_W-1:0]         wr_data,
  output logic [NUM_PID*PID_W-1:0] pid_flat
);

  logic wr_ok;
  assign wr_ok = wr_en && (priv_lvl == 2'd0);

  for (genvar g = 0; g < NUM_PID; g++) begin : g_slot
    logic             ld_en;
    logic [PID_W-1:0] slot_q;
    logic [PID_W-1:0] slot_d;

    always_comb begin
      ld_en  = wr_ok && (wr_sel == SEL_W'(g));
      slot_d = ld_en ? wr_data : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign pid_flat[g*PID_W +: PID_W] = slot_q;
  end

endmodule

// File: rtl/pid_match.sv
module pid_match #(
  parameter int NUM_PID = 4,
  parameter int AID_W   = 15,
  localparam int PID_W  = AID_W + 1
) (
  input  logic [NUM_PID*PID_W-1:0] pid_flat,
  input  logic [AID_W-1:0]         page_aid,
  input  logic                     is_write,
  output logic                     id_ok
);

  logic [NUM_PID-1:0] hit;
  logic [NUM_PID-1:0] hit_rw;
  logic               is_public;

  for (genvar g = 0; g < NUM_PID; g++) begin : g_cmp
    logic [PID_W-1:0] entry;
    assign entry     = pid_flat[g*PID_W +: PID_W];
    assign hit[g]    = (entry[AID_W-1:0] == page_aid);
    assign hit_rw[g] = hit[g] && !entry[AID_W];
  end

  always_comb begin
    is_public = (page_aid == '0);
    id_ok     = is_public || (is_write ? (|hit_rw) : (|hit));
  end

endmodule

// File: rtl/rights_check.sv
module rights_check
  import prot_check_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rights,
  input  logic [PL_W-1:0]     priv_lvl,
  input  logic [1:0]          req_type,
  output logic                rights_ok
);

  logic [KIND_W-1:0] kind;
  logic [PL_W-1:0]   pl_rd;
  logic [PL_W-1:0]   pl_wx;
  logic [2:0]        perm;
  logic              rd_lvl_ok;
  logic              wx_lvl_ok;

  always_comb begin
    kind      = rights[RIGHTS_W-1 -: KIND_W];
    pl_rd     = rights[2*PL_W-1 -: PL_W];
    pl_wx     = rights[PL_W-1:0];
    perm      = kind_perm(kind);
    rd_lvl_ok = (priv_lvl <= pl_rd);
    wx_lvl_ok = (priv_lvl <= pl_wx);
    unique case (acc_t'(req_type))
      ACC_READ:  rights_ok = perm[2] && rd_lvl_ok;
      ACC_WRITE: rights_ok = perm[1] && wx_lvl_ok;
      ACC_EXEC:  rights_ok = perm[0] && wx_lvl_ok;
      default:   rights_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/prot_check_unit.sv
module prot_check_unit #(
  parameter int NUM_PID = 4,
  parameter int AID_W   = 15,
  localparam int PID_W  = AID_W + 1,
  localparam int SEL_W  = $clog2(NUM_PID)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          priv_lvl,
  input  logic                                req_valid,
  input  logic [1:0]                          req_type,
  input  logic [prot_check_pkg::RIGHTS_W-1:0] page_rights,
  input  logic [AID_W-1:0]                    page_aid,
  input  logic                                pid_we,
  input  logic [SEL_W-1:0]                    pid_sel,
  input  logic [PID_W-1:0]                    pid_wdata,
  output logic                                res_valid,
  output logic                                allow,
  output logic                                rights_fault,
  output logic                                id_fault
);
  import prot_check_pkg::*;

  logic [NUM_PID*PID_W-1:0] pid_flat;
  logic                     rights_ok;
  logic                     id_ok;
  logic                     is_write;

  logic valid_d, allow_d, rf_d, idf_d;

  assign is_write = (req_type == ACC_WRITE);

  pid_regfile #(.NUM_PID(NUM_PID), .PID_W(PID_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_lvl (priv_lvl),
    .wr_en    (pid_we),
    .wr_sel   (pid_sel),
    .wr_data  (pid_wdata),
    .pid_flat (pid_flat)
  );

  pid_match #(.NUM_PID(NUM_PID), .AID_W(AID_W)) u_match (
    .pid_flat (pid_flat),
    .page_aid (page_aid),
    .is_write (is_write),
    .id_ok    (id_ok)
  );

  rights_check u_rights (
    .rights    (page_rights),
    .priv_lvl  (priv_lvl),
    .req_type  (req_type),
    .rights_ok (rights_ok)
  );

  always_comb begin
    valid_d = req_valid;
    rf_d    = req_valid && !rights_ok;
    idf_d   = req_valid && rights_ok && !id_ok;
    allow_d = req_valid && rights_ok && id_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      allow        <= 1'b0;
      rights_fault <= 1'b0;
      id_fault     <= 1'b0;
    end else begin
      res_valid    <= valid_d;
      allow        <= allow_d;
      rights_fault <= rf_d;
      id_fault     <= idf_d;
    end
  end

endmodule

// File: rtl/prot_check_sva.sv
module prot_check_sva #(
  parameter int NUM_PID = 4,
  parameter int AID_W   = 15,
  localparam int PID_W  = AID_W + 1,
  localparam int SEL_W  = $clog2(NUM_PID)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               priv_lvl,
  input logic                     req_valid,
  input logic [1:0]               req_type,
  input logic [6:0]               page_rights,
  input logic [AID_W-1:0]         page_aid,
  input logic                     pid_we,
  input logic [SEL_W-1:0]         pid_sel,
  input logic [PID_W-1:0]         pid_wdata,
  input logic                     res_valid,
  input logic                     allow,
  input logic                     rights_fault,
  input logic                     id_fault,
  input logic [NUM_PID*PID_W-1:0] pid_flat
);

  logic [PID_W-1:0] slot_arr [NUM_PID];
  always_comb begin
    for (int i = 0; i < NUM_PID; i++) slot_arr[i] = pid_flat[i*PID_W +: PID_W];
  end

  p_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_nofollow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({allow, rights_fault, id_fault}) == 1));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(allow || rights_fault || id_fault));
  p_public_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_aid == '0) |=> !id_fault);
  p_exonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd0 && page_rights[6]) |=> rights_fault);
  p_ronly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd1 && page_rights[6:4] == 3'd0) |=> rights_fault);
  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pid_we && priv_lvl != 2'd0) |=> $stable(pid_flat));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pid_we && priv_lvl == 2'd0) |=> (slot_arr[$past(pid_sel)] == $past(pid_wdata)));

endmodule

bind prot_check_unit prot_check_sva #(.NUM_PID(NUM_PID), .AID_W(AID_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .priv_lvl     (priv_lvl),
  .req_valid    (req_valid),
  .req_type     (req_type),
  .page_rights  (page_rights),
  .page_aid     (page_aid),
  .pid_we       (pid_we),
  .pid_sel      (pid_sel),
  .pid_wdata    (pid_wdata),
  .res_valid    (res_valid),
  .allow        (allow),
  .rights_fault (rights_fault),
  .id_fault     (id_fault),
  .pid_flat     (pid_flat)
);

// File: tb/prot_check_unit_bench.sv
`timescale 1ns/1ps
module prot_check_unit_bench;

  localparam int V_ALLOW = 0;
  localparam int V_RF    = 1;
  localparam int V_IDF   = 2;

  logic        clk;
  logic        rst_n;
  logic [1:0]  priv_lvl;
  logic        req_valid;
  logic [1:0]  req_type;
  logic [6:0]  page_rights;
  logic [14:0] page_aid;
  logic        pid_we;
  logic [1:0]  pid_sel;
  logic [15:0] pid_wdata;
  logic        res_valid, allow, rights_fault, id_fault;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  prot_check_unit u_prot_check_unit (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .req_valid(req_valid),
    .req_type(req_type), .page_rights(page_rights), .page_aid(page_aid),
    .pid_we(pid_we), .pid_sel(pid_sel), .pid_wdata(pid_wdata),
    .res_valid(res_valid), .allow(allow), .rights_fault(rights_fault),
    .id_fault(id_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [6:0] rt(input int kind, input int plr, input int plw);
    return {kind[2:0], plr[1:0], plw[1:0]};
  endfunction

  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {res_valid, allow, rights_fault, id_fault};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s {valid,allow,rf,idf} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic access(input string req, input int lvl, input int typ,
                        input logic [6:0] rights, input int aid, input int verdict);
    @(negedge clk);
    priv_lvl    = lvl[1:0];
    req_type    = typ[1:0];
    page_rights = rights;
    page_aid    = aid[14:0];
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    case (verdict)
      V_ALLOW: expect_out(req, 4'b1100);
      V_RF:    expect_out(req, 4'b1010);
      default: expect_out(req, 4'b1001);
    endcase
  endtask

  task automatic load_pid(input int lvl, input int sel, input logic [15:0] val);
    @(negedge clk);
    priv_lvl  = lvl[1:0];
    pid_sel   = sel[1:0];
    pid_wdata = val;
    pid_we    = 1'b1;
    @(negedge clk);
    pid_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; priv_lvl = 0; req_valid = 0; req_type = 0;
    page_rights = 0; page_aid = 0; pid_we = 0; pid_sel = 0; pid_wdata = 0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", 4'b0000);
    access("R1 cleared regs", 0, 0, rt(3, 3, 3), 15'h0005, V_IDF);
  endtask

  task automatic t_read;
    load_pid(0, 0, 16'h0123);
    access("R2 read at read level", 2, 0, rt(1, 2, 0), 15'h0123, V_ALLOW);
    access("R2 read above read level", 3, 0, rt(1, 2, 0), 15'h0123, V_RF);
    access("R2 read of exec-only kind", 0, 0, rt(4, 3, 3), 15'h0123, V_RF);
  endtask

  task automatic t_write;
    access("R3 write at level 0", 0, 1, rt(1, 2, 0), 15'h0123, V_ALLOW);
    access("R3 write at level 1", 1, 1, rt(1, 2, 0), 15'h0123, V_RF);
    access("R3 write to read-only kind", 0, 1, rt(0, 3, 3), 15'h0123, V_RF);
    access("R3 write rwx at level 3", 3, 1, rt(3, 3, 3), 15'h0123, V_ALLOW);
    access("R3 write to read/exec kind", 0, 1, rt(2, 3, 3), 15'h0123, V_RF);
  endtask

  task automatic t_exec;
    access("R4 exec at wx level", 1, 2, rt(2, 3, 1), 15'h0123, V_ALLOW);
    access("R4 exec above wx level", 2, 2, rt(2, 3, 1), 15'h0123, V_RF);
    access("R4 exec gateway kind", 3, 2, rt(7, 0, 3), 15'h0123, V_ALLOW);
    access("R4 exec of read-only kind", 0, 2, rt(0, 3, 3), 15'h0123, V_RF);
    access("R4 reserved type", 0, 3, rt(3, 3, 3), 15'h0123, V_RF);
    access("R4 write of exec-only kind", 0, 1, rt(5, 3, 3), 15'h0123, V_RF);
  endtask

  task automatic t_match;
    load_pid(0, 1, 16'h0200);
    load_pid(0, 2, 16'h0300);
    load_pid(0, 3, 16'h7FFF);
    access("R5 slot 0", 0, 1, rt(3, 3, 3), 15'h0123, V_ALLOW);
    access("R5 slot 1", 0, 1, rt(3, 3, 3), 15'h0200, V_ALLOW);
    access("R5 slot 2", 0, 1, rt(3, 3, 3), 15'h0300, V_ALLOW);
    access("R5 slot 3", 0, 1, rt(3, 3, 3), 15'h7FFF, V_ALLOW);
    access("R7 unmatched id", 0, 0, rt(3, 3, 3), 15'h0456, V_IDF);
  endtask

  task automatic t_wdis;
    load_pid(0, 2, 16'h8456);
    access("R6 read through wd slot", 0, 0, rt(3, 3, 3), 15'h0456, V_ALLOW);
    access("R6 exec through wd slot", 0, 2, rt(3, 3, 3), 15'h0456, V_ALLOW);
    access("R6 write through wd slot", 0, 1, rt(3, 3, 3), 15'h0456, V_IDF);
    load_pid(0, 3, 16'h0456);
    access("R6 write with clear twin", 0, 1, rt(3, 3, 3), 15'h0456, V_ALLOW);
  endtask

  task automatic t_public;
    access("R8 public write", 0, 1, rt(1, 0, 0), 15'h0000, V_ALLOW);
    access("R8 public read level 3", 3, 0, rt(0, 3, 0), 15'h0000, V_ALLOW);
    access("R8 public bad rights", 3, 1, rt(1, 3, 0), 15'h0000, V_RF);
  endtask

  task automatic t_pidwr;
    load_pid(1, 0, 16'h0777);
    access("R9 level 1 write ignored, new id", 0, 0, rt(3, 3, 3), 15'h0777, V_IDF);
    access("R9 level 1 write ignored, old id", 0, 0, rt(3, 3, 3), 15'h0123, V_ALLOW);
    load_pid(3, 1, 16'h0777);
    access("R9 level 3 write ignored", 0, 0, rt(3, 3, 3), 15'h0200, V_ALLOW);
    load_pid(0, 0, 16'h0777);
    access("R9 level 0 write loads", 0, 0, rt(3, 3, 3), 15'h0777, V_ALLOW);
    access("R9 level 0 write replaces", 0, 0, rt(3, 3, 3), 15'h0123, V_IDF);
  endtask

  task automatic t_prio;
    access("R10 both fail", 3, 1, rt(0, 0, 0), 15'h0ABC, V_RF);
    access("R10 rights fail wd write", 0, 1, rt(0, 3, 3), 15'h0456, V_RF);
  endtask

  task automatic t_timing;
    @(negedge clk);
    priv_lvl = 0; req_type = 0; page_rights = rt(3, 3, 3); page_aid = 15'h0200;
    req_valid = 1'b1;
    @(negedge clk);
    expect_out("R11 first of back-to-back", 4'b1100);
    page_aid = 15'h0BAD;
    @(negedge clk);
    req_valid = 1'b0;
    expect_out("R11 second of back-to-back", 4'b1001);
    @(negedge clk);
    expect_out("R11 idle after request", 4'b0000);
  endtask

  initial begin
    t_reset;
    t_read;
    t_write;
    t_exec;
    t_match;
    t_wdis;
    t_public;
    t_pidwr;
    t_prio;
    t_timing;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule